// File: doc/BRIEF.md
# Eight-Channel Match Timer Bank

This block holds eight timer channels, numbered 4 to 11. Each channel has a 32-bit counter, a 32-bit compare value and a control word. Each counter advances on one of five tick-enable inputs, and the control word picks which one. A channel may compare its own counter against its compare value. It may instead compare the counter of its group leader: channel 4 leads channels 4–7, channel 8 leads channels 8–9 and channel 10 leads channels 10–11. A channel can also clear its counter on a match and can fire periodically or only once.

Matches post into a status field that is gated by an enable field. The status bits of the eight channels are ORed into one level interrupt. Channels 9 and 11 can be set so that reading their counter freezes the current value of counter 8 or counter 10 into a snapshot register. Software reaches the block through a word register port with a byte address. Writes take effect at the clock edge. Read data is combinational from the address.

Top module: `mtb_bank`

## Requirements
- R1: Control field [2:0] chooses the count source: 1 = tick_i[0] (32.768 kHz), 2 = tick_i[1] (1 kHz), 3 = tick_i[2] (1 Hz), 4 = tick_i[3] (1 MHz), 5 = tick_i[4] (external). Values 0, 6 and 7 stop the counter. A counter that runs gains exactly 1 on each clock edge where its selected tick is high.
- R2: With control bit 7 set, a channel compares its own counter. With bit 7 clear, it compares the counter of its group leader: 4 for channels 4–7, 8 for channels 8–9, 10 for channels 10–11.
- R3: A channel that is not a leader and has bit 7 clear never advances its own counter. The leaders 4, 8 and 10 count from field [2:0] whatever the state of bit 7.
- R4: A match event happens on the cycle when the compared counter changes from unequal to equal to the compare value. If control bit 3 is set, the event returns the channel's own counter to 0 on the next edge.
- R5: With control bit 6 set, every match event fires. With bit 6 clear, the channel fires once and then stays silent until its compare value or counter is written.
- R6: On channels 8–11, control bit 8 stops the channel's own counter even when a tick is selected.
- R7: Suppose channel 9 (or 11) has control bit 9 set. A read with rd_en_i at that channel's counter address then copies the present value of counter 8 (or 10) into the snapshot register at 0x20. With bit 9 clear, the snapshot register keeps its value.
- R8: Control words keep bits [7:0] on channels 4–7 and bits [9:0] on channels 8–11. All other bits read 0.
- R9: A match event sets status bit n (4–11) only if enable bit n is set. Status is visible one edge after the event. irq_o is high while any status bit is set.
- R10: Writing the status register at 0x14 clears every status bit written as 1. Bits written as 0, and bits that were not set, are unchanged.
- R11: Writing a counter loads it on the next edge. A stopped counter holds its value and reads it back unchanged.
- R12: Addresses: counters at 0x40 + 4·(n−4), compare values at 0x80 + 4·(n−4), control words at 0xC0 + 4·(n−4), status at 0x14, enable at 0x1C, snapshot at 0x20. Status and enable read bits 11:4 only. Any other address reads 0.
- R13: After reset, all counters, compare values, control words, status, enable and the snapshot are 0, and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (arms snapshot capture) |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| tick_i | input | 5 | Tick enables: 32.768 kHz, 1 kHz, 1 Hz, 1 MHz, external |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Shared bank interrupt |

## Verification
The counters are driven with single ticks on one source at a time, then with all sources at once. This separates a correct source decode from one that miscounts or picks up a neighbouring tick. Matches are tried in four ways: through a follower channel compared against its leader, through an own-counter channel, with and without clear-on-match, and in one-shot and periodic modes. Together these separate the choice of compare source from the re-arm rules. Status clearing is tried with two bits pending, which shows whether irq_o follows the remaining bit. Snapshot reads happen after the source counter has moved on, so a stale or wrongly paired capture gives a different value.

// File: rtl/mtb_pkg.sv
package mtb_pkg;
  localparam int NUM_CH   = 8;
  localparam int FIRST_CH = 4;
  localparam int NUM_TICK = 5;
  localparam int CTRL_W   = 10;

  localparam int OFS_STATUS = 'h14;
  localparam int OFS_ENABLE = 'h1C;
  localparam int OFS_SNAP   = 'h20;
  localparam int OFS_CNT    = 'h40;
  localparam int OFS_MATCH  = 'h80;
  localparam int OFS_CTRL   = 'hC0;

  localparam int CB_CLR_ON_MATCH = 3;
  localparam int CB_PERIODIC     = 6;
  localparam int CB_OWN_CNT      = 7;
  localparam int CB_EXT_SYNC     = 8;
  localparam int CB_SNAP_EN      = 9;

  function automatic int leader_of(input int ch);
    if (ch < 8) return 4;
    else if (ch < 10) return 8;
    else return 10;
  endfunction
endpackage

// File: rtl/mtb_channel.sv
module mtb_channel
  import mtb_pkg::*;
#(
  parameter int CH_IDX = 4,
  parameter int CNT_W  = 32,
  parameter int N_TICK = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TICK-1:0] tick_i,
  input  logic              wr_cnt_i,
  input  logic              wr_match_i,
  input  logic              wr_ctrl_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  lead_cnt_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  match_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              fire_o
);
  localparam bit IS_LEADER = (leader_of(CH_IDX) == CH_IDX);
  localparam bit HAS_EXT   = (CH_IDX >= 8);
  localparam int KEEP_W    = HAS_EXT ? CTRL_W : 8;
  localparam logic [CTRL_W-1:0] KEEP_MASK = CTRL_W'((1 << KEEP_W) - 1);

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt_q, match_q, cmp;
  logic              armed_q, hit_q;
  logic              tick_sel, run, hit, fire, ext_stop;

  always_comb begin
    tick_sel = 1'b0;
    for (int k = 0; k < N_TICK; k++)
      if (int'(ctrl_q[2:0]) == k + 1) tick_sel = tick_i[k];
  end

  assign ext_stop = HAS_EXT && ctrl_q[CB_EXT_SYNC];
  assign run      = (ctrl_q[CB_OWN_CNT] || IS_LEADER) && !ext_stop && tick_sel;
  assign cmp      = ctrl_q[CB_OWN_CNT] ? cnt_q : lead_cnt_i;
  assign hit      = (cmp == match_q);
  // edge of equality; one-shot needs the arm flag
  assign fire     = hit && !hit_q && (armed_q || ctrl_q[CB_PERIODIC]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      cnt_q   <= '0;
      match_q <= '0;
      armed_q <= 1'b1;
      hit_q   <= 1'b1;
    end else begin
      hit_q <= hit;
      if (wr_ctrl_i)  ctrl_q  <= wdata_i[CTRL_W-1:0] & KEEP_MASK;
      if (wr_match_i) match_q <= wdata_i;
      if (wr_cnt_i)                                 cnt_q <= wdata_i;
      else if (fire && ctrl_q[CB_CLR_ON_MATCH])    cnt_q <= '0;
      else if (run)                                 cnt_q <= cnt_q + CNT_W'(1);
      if (wr_cnt_i || wr_match_i) armed_q <= 1'b1;
      else if (fire)              armed_q <= 1'b0;
    end
  end

  assign cnt_o   = cnt_q;
  assign match_o = match_q;
  assign ctrl_o  = ctrl_q;
  assign fire_o  = fire;

  p_clear_on_match_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && ctrl_q[CB_CLR_ON_MATCH] && !wr_cnt_i |=> cnt_q == '0);

  p_oneshot_disarm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !ctrl_q[CB_PERIODIC] && !wr_cnt_i && !wr_match_i |=> !armed_q);

  p_stopped_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_sel && !wr_cnt_i && !(fire && ctrl_q[CB_CLR_ON_MATCH]) |=> $stable(cnt_q));

  if (!IS_LEADER) begin : g_follower
    p_follower_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_q[CB_OWN_CNT] && !wr_cnt_i && !(fire && ctrl_q[CB_CLR_ON_MATCH])
      |=> $stable(cnt_q));
  end

  if (HAS_EXT) begin : g_ext
    p_ext_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_q[CB_EXT_SYNC] && !wr_cnt_i && !(fire && ctrl_q[CB_CLR_ON_MATCH])
      |=> $stable(cnt_q));
  end
endmodule

// File: rtl/mtb_irq.sv
module mtb_irq #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_reg_i,
  input  logic         wr_stat_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] fire_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] stat_o,
  output logic         irq_o
);
  logic [N-1:0] en_q, stat_q, stat_d;
  logic         irq_q;

  // a new event wins over a clear in the same cycle
  assign stat_d = (stat_q & ~(wr_stat_i ? wdata_i : '0)) | (fire_i & en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_en_reg_i) en_q <= wdata_i;
      stat_q <= stat_d;
      irq_q  <= |stat_d;
    end
  end

  assign en_o   = en_q;
  assign stat_o = stat_q;
  assign irq_o  = irq_q;

  p_status_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & ~$past(stat_q) & ~$past(en_q)) == '0);

  p_irq_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|stat_q));

  p_w1c_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat_i && fire_i == '0 |=> (stat_q & $past(wdata_i & stat_q)) == '0);
endmodule

// File: rtl/mtb_bank.sv
module mtb_bank
  import mtb_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [CNT_W-1:0]    wdata_i,
  input  logic [NUM_TICK-1:0] tick_i,
  output logic [CNT_W-1:0]    rdata_o,
  output logic                irq_o
);
  localparam int IDX_A = 9 - FIRST_CH;   // snapshot channel over leader 8
  localparam int IDX_B = 11 - FIRST_CH;  // snapshot channel over leader 10

  logic [CNT_W-1:0]  cnt_w   [NUM_CH];
  logic [CNT_W-1:0]  match_w [NUM_CH];
  logic [CTRL_W-1:0] ctrl_w  [NUM_CH];
  logic [NUM_CH-1:0] wr_cnt, wr_match, wr_ctrl, fire_vec, en_w, stat_w;
  logic [CNT_W-1:0]  snap_q;
  logic              wr_enable, wr_status;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int LEAD = leader_of(FIRST_CH + g) - FIRST_CH;
    assign wr_cnt[g]   = wr_en_i && (addr_i == ADDR_W'(OFS_CNT + 4 * g));
    assign wr_match[g] = wr_en_i && (addr_i == ADDR_W'(OFS_MATCH + 4 * g));
    assign wr_ctrl[g]  = wr_en_i && (addr_i == ADDR_W'(OFS_CTRL + 4 * g));

    mtb_channel #(
      .CH_IDX(FIRST_CH + g),
      .CNT_W (CNT_W),
      .N_TICK(NUM_TICK)
    ) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .wr_cnt_i  (wr_cnt[g]),
      .wr_match_i(wr_match[g]),
      .wr_ctrl_i (wr_ctrl[g]),
      .wdata_i   (wdata_i),
      .lead_cnt_i(cnt_w[LEAD]),
      .cnt_o     (cnt_w[g]),
      .match_o   (match_w[g]),
      .ctrl_o    (ctrl_w[g]),
      .fire_o    (fire_vec[g])
    );
  end

  assign wr_enable = wr_en_i && (addr_i == ADDR_W'(OFS_ENABLE));
  assign wr_status = wr_en_i && (addr_i == ADDR_W'(OFS_STATUS));

  mtb_irq #(.N(NUM_CH)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_reg_i(wr_enable),
    .wr_stat_i  (wr_status),
    .wdata_i    (wdata_i[FIRST_CH +: NUM_CH]),
    .fire_i     (fire_vec),
    .en_o       (en_w),
    .stat_o     (stat_w),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
    end else if (rd_en_i) begin
      if (addr_i == ADDR_W'(OFS_CNT + 4 * IDX_A) && ctrl_w[IDX_A][CB_SNAP_EN])
        snap_q <= cnt_w[IDX_A - 1];
      else if (addr_i == ADDR_W'(OFS_CNT + 4 * IDX_B) && ctrl_w[IDX_B][CB_SNAP_EN])
        snap_q <= cnt_w[IDX_B - 1];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_STATUS)) rdata_o = CNT_W'({stat_w, {FIRST_CH{1'b0}}});
    if (addr_i == ADDR_W'(OFS_ENABLE)) rdata_o = CNT_W'({en_w, {FIRST_CH{1'b0}}});
    if (addr_i == ADDR_W'(OFS_SNAP))   rdata_o = snap_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr_i == ADDR_W'(OFS_CNT + 4 * i))   rdata_o = cnt_w[i];
      if (addr_i == ADDR_W'(OFS_MATCH + 4 * i)) rdata_o = match_w[i];
      if (addr_i == ADDR_W'(OFS_CTRL + 4 * i))  rdata_o = CNT_W'(ctrl_w[i]);
    end
  end

  p_snap_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == ADDR_W'(OFS_CNT + 4 * IDX_A) && ctrl_w[IDX_A][CB_SNAP_EN]
    |=> snap_q == $past(cnt_w[IDX_A - 1]));

  p_irq_from_event_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|fire_vec));
endmodule

// File: tb/tb_mtb_bank.sv
module tb_mtb_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [4:0]  tick = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mtb_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .tick_i(tick), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [7:0] a_cnt(input int ch);   return 8'('h40 + 4 * (ch - 4)); endfunction
  function automatic logic [7:0] a_match(input int ch); return 8'('h80 + 4 * (ch - 4)); endfunction
  function automatic logic [7:0] a_ctrl(input int ch);  return 8'('hC0 + 4 * (ch - 4)); endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; tick = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp,
                        input bit strobe = 1'b0);
    @(negedge clk);
    addr = a; rd_en = strobe;
    #1 chk(req, rdata, exp);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = m;
      @(negedge clk); tick = '0;
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    rd_chk("R13 cnt4", a_cnt(4), 0);
    rd_chk("R13 ctrl11", a_ctrl(11), 0);
    rd_chk("R13 match7", a_match(7), 0);
    rd_chk("R13 status", 8'h14, 0);
    rd_chk("R13 snapshot", 8'h20, 0);
    chk("R13 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_clock_select();
    do_reset();
    wr(a_ctrl(4), 1);  pulse(5'b00001, 5); rd_chk("R1 sel1 32k", a_cnt(4), 5);
    pulse(5'b00010, 3); rd_chk("R1 sel1 ignores 1k", a_cnt(4), 5);
    wr(a_ctrl(4), 4);  pulse(5'b01000, 2); rd_chk("R1 sel4 1MHz", a_cnt(4), 7);
    wr(a_ctrl(4), 5);  pulse(5'b10000, 1); rd_chk("R1 sel5 ext", a_cnt(4), 8);
    wr(a_ctrl(4), 6);  pulse(5'b11111, 2); rd_chk("R1 sel6 stopped", a_cnt(4), 8);
    wr(a_ctrl(4), 0);  pulse(5'b11111, 2); rd_chk("R11 sel0 holds", a_cnt(4), 8);
    wr(a_ctrl(4), 2);  pulse(5'b00010, 1); rd_chk("R1 sel2 1k", a_cnt(4), 9);
    wr(a_ctrl(4), 3);  pulse(5'b00100, 1); rd_chk("R1 sel3 1Hz", a_cnt(4), 10);
  endtask

  task automatic t_groups();
    do_reset();
    wr(a_ctrl(4), 1); wr(a_ctrl(8), 1); wr(a_ctrl(5), 1);
    wr(a_match(5), 3); wr(8'h1C, 32'h20);
    pulse(5'b00001, 3);
    rd_chk("R2 follower matches leader", 8'h14, 32'h20);
    chk("R9 irq set", {31'b0, irq}, 1);
    rd_chk("R3 follower own counter frozen", a_cnt(5), 0);
    rd_chk("R3 leader8 counts bit7 clear", a_cnt(8), 3);
    wr(a_ctrl(5), 32'h81); pulse(5'b00001, 2);
    rd_chk("R2 own mode counts", a_cnt(5), 2);
  endtask

  task automatic t_enable_w1c();
    do_reset();
    wr(a_ctrl(4), 1); wr(a_match(4), 2);
    pulse(5'b00001, 2);
    rd_chk("R9 no enable no status", 8'h14, 0);
    chk("R9 no enable no irq", {31'b0, irq}, 0);
    wr(8'h1C, 32'h50); wr(a_match(4), 4);
    wr(a_ctrl(6), 32'h81); wr(a_match(6), 1);
    pulse(5'b00001, 2);
    rd_chk("R9 two pending", 8'h14, 32'h50);
    wr(8'h14, 32'h10);
    rd_chk("R10 clear one bit", 8'h14, 32'h40);
    chk("R10 irq stays", {31'b0, irq}, 1);
    wr(8'h14, 32'h400);
    rd_chk("R10 unset bit no effect", 8'h14, 32'h40);
    wr(8'h14, 32'h40);
    rd_chk("R10 all clear", 8'h14, 0);
    chk("R10 irq drops", {31'b0, irq}, 0);
  endtask

  task automatic t_clear_on_match();
    do_reset();
    wr(a_ctrl(6), 32'h89); wr(a_match(6), 4); wr(8'h1C, 32'h40);
    pulse(5'b00001, 6);
    rd_chk("R4 counter restarted", a_cnt(6), 2);
    rd_chk("R4 event posted", 8'h14, 32'h40);
  endtask

  task automatic t_oneshot_periodic();
    do_reset();
    wr(a_ctrl(7), 32'h89); wr(a_match(7), 2); wr(8'h1C, 32'h80);
    pulse(5'b00001, 2);
    rd_chk("R5 one-shot fires", 8'h14, 32'h80);
    wr(8'h14, 32'h80);
    pulse(5'b00001, 2);
    rd_chk("R5 one-shot silent", 8'h14, 0);
    rd_chk("R5 no clear when silent", a_cnt(7), 2);
    wr(a_cnt(7), 0); pulse(5'b00001, 2);
    rd_chk("R5 counter write re-arms", 8'h14, 32'h80);
    wr(a_ctrl(7), 32'hC9); wr(8'h14, 32'h80);
    pulse(5'b00001, 2);
    rd_chk("R5 periodic first", 8'h14, 32'h80);
    wr(8'h14, 32'h80);
    pulse(5'b00001, 2);
    rd_chk("R5 periodic again", 8'h14, 32'h80);
  endtask

  task automatic t_ext_sync();
    do_reset();
    wr(a_ctrl(8), 32'h101); wr(a_ctrl(10), 32'h181);
    pulse(5'b00001, 3);
    rd_chk("R6 leader8 ext holds", a_cnt(8), 0);
    rd_chk("R6 ch10 ext holds", a_cnt(10), 0);
    wr(a_ctrl(8), 1); pulse(5'b00001, 1);
    rd_chk("R6 released counts", a_cnt(8), 1);
  endtask

  task automatic t_snapshot();
    do_reset();
    wr(a_ctrl(8), 1); wr(a_ctrl(10), 1);
    pulse(5'b00001, 5);
    wr(a_cnt(10), 100);
    wr(a_ctrl(9), 32'h200); wr(a_ctrl(11), 32'h200);
    rd_chk("R7 ch9 reads own", a_cnt(9), 0, 1'b1);
    rd_chk("R7 snapshot of 8", 8'h20, 5);
    pulse(5'b00001, 2);
    rd_chk("R7 snapshot held", 8'h20, 5);
    rd_chk("R11 counter write loaded", a_cnt(10), 102);
    rd_chk("R7 ch11 read", a_cnt(11), 0, 1'b1);
    rd_chk("R7 snapshot of 10", 8'h20, 102);
    wr(a_ctrl(9), 0);
    rd_chk("R7 disabled read", a_cnt(9), 0, 1'b1);
    rd_chk("R7 disabled keeps", 8'h20, 102);
  endtask

  task automatic t_regs();
    do_reset();
    wr(a_ctrl(4), 32'hFFFF_FFFF);
    rd_chk("R8 ctrl4 width", a_ctrl(4), 32'hFF);
    wr(a_ctrl(9), 32'hFFFF_FFFF);
    rd_chk("R8 ctrl9 width", a_ctrl(9), 32'h3FF);
    wr(8'h1C, 32'hFFFF_FFFF);
    rd_chk("R12 enable bits 11:4", 8'h1C, 32'hFF0);
    rd_chk("R12 unused address", 8'h00, 0);
    wr(a_cnt(4), 32'h1234);
    pulse(5'b11111, 2);
    rd_chk("R11 stopped load holds", a_cnt(4), 32'h1234);
    wr(a_match(11), 32'hCAFE);
    rd_chk("R12 match11 offset", 8'h9C, 32'hCAFE);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    t_reset_state();
    t_clock_select();
    t_groups();
    t_enable_w1c();
    t_clear_on_match();
    t_oneshot_periodic();
    t_ext_sync();
    t_snapshot();
    t_regs();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R13 actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule